// File: doc/BRIEF.md
# PCI Host Bridge Register Block

This block is the processor-facing register window of an on-chip PCI host controller. It spans 0x224 bytes of 32-bit registers. The low 256 bytes hold the host function's own 64-dword configuration header. A configuration address latch, a memory base register and an I/O base register follow. A data port turns every access into a single configuration cycle on the downstream bus. The port uses a simple request/done handshake, and the register bus is stalled until that cycle finishes or times out.

The block also compares system addresses against a 256 KB I/O window placed at the programmed I/O base. It reports a hit together with the offset inside the window. Interrupt requests from downstream sources are steered onto four interrupt lines, chosen by each source's device number.

Top module: `pci_host_regblk`

## Requirements
- R1: Byte offsets 0x004 to 0x0FC address header dwords 1 to 63, which can be read and written as full 32-bit words.
- R2: Header dword 0 at offset 0x000 reads as {DEVICE_ID, VENDOR_ID} (device ID in bits 31:16), and writes to it are ignored.
- R3: After reset, header dword 1 reads 0x0290_0080, the I/O base reads 0xFE24_0000, the address latch reads 0 and the memory base reads 0. In dword 1 the command bit 7 is wait-cycle control, and the status bits 4, 7 and 10:9=01 are capability list, fast back-to-back and medium select timing.
- R4: The configuration address latch at 0x1C0 stores and returns all 32 written bits.
- R5: The memory base at 0x1C4 keeps only written bits 31:24 and bit 0. Every other bit reads back as zero.
- R6: The I/O base at 0x1C8 keeps written bits 31:18 and bit 0, but only when the written bits 31:18 differ from the stored ones. Otherwise the whole write, bit 0 included, is ignored.
- R7: An access with byte enables other than 4'hF, or to an unmapped offset, completes in its first cycle. Its read returns zero and its write changes nothing.
- R8: An access to the data port at 0x220 holds cfgReq high, with cfgAddr equal to the address latch, until cfgDone. A write sends busWdata, and a read returns cfgRdata. busReady stays low until the cycle after cfgDone.
- R9: If cfgDone does not arrive within 256 cycles of cfgReq rising, the access ends anyway, and a read returns 0xFFFF_FFFF.
- R10: ioHit is high exactly when ioAddr[31:18] equals I/O base bits 31:18, and ioOffset equals ioAddr[17:0].
- R11: intLine[n] is the OR of every active source whose devfn bits 7:3 equal n. A source with a device number of 4 or more drives no line.
- R12: During a data-port access, busReady is low for exactly latency+3 cycles when the downstream side raises cfgDone latency+1 edges after cfgReq rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Register access request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte offset of the access |
| busBe | input | 4 | Byte enables; only 4'hF is accepted |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid when busReady is high |
| busReady | output | 1 | Access completes in this cycle |
| cfgReq | output | 1 | Downstream configuration cycle pending |
| cfgWrite | output | 1 | Downstream cycle is a write |
| cfgAddr | output | 32 | Downstream configuration address |
| cfgWdata | output | 32 | Downstream write data |
| cfgDone | input | 1 | Downstream completion pulse |
| cfgRdata | input | 32 | Downstream read data, valid with cfgDone |
| ioAddr | input | 32 | System address to test against the I/O window |
| ioHit | output | 1 | ioAddr lies inside the I/O window |
| ioOffset | output | 18 | Offset of ioAddr inside the window |
| intSrc | input | NUM_SRC | Interrupt request from each downstream source |
| intDevfn | input | 8*NUM_SRC | Device/function number of each source |
| intLine | output | 4 | Interrupt lines |

## Verification
Register reads, ignored accesses, window decode and interrupt steering are combinational. They are checked one time unit after inputs change at the falling edge, and register writes are read back on the following access. A data-port access stalls for one decode cycle, then for the downstream latency plus two waiting cycles, and is ready in the cycle after that. The bench counts the stalled cycles and compares the count with latency+3. For the stuck case it expects 257 stalled cycles and all ones. The downstream model counts rising edges with cfgReq high, so the point at which cfgDone lands is fixed by the bench and does not depend on the design.

// File: rtl/pci_host_pkg.sv
package pci_host_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic regWe;        // commit an ordinary register write
    logic respLatch;    // capture downstream read data
    logic respTimeout;  // capture all ones instead
    logic respSel;      // drive captured response onto busRdata
  } ctrlStrb_t;

  localparam logic [7:0] IDX_ADDR  = 8'h70;  // byte 0x1C0
  localparam logic [7:0] IDX_MBASE = 8'h71;  // byte 0x1C4
  localparam logic [7:0] IDX_IOB   = 8'h72;  // byte 0x1C8
  localparam logic [7:0] IDX_PORT  = 8'h88;  // byte 0x220

  localparam logic [31:0] MBASE_MASK = 32'hFF00_0001;
  localparam logic [31:0] IOB_MASK   = 32'hFFFC_0001;
  localparam logic [31:0] IOB_RESET  = 32'hFE24_0000;
  localparam logic [31:0] HDR1_RESET = 32'h0290_0080;

endpackage

// File: rtl/pci_host_ctrl.sv
module pci_host_ctrl
  import pci_host_pkg::*;
#(
  parameter int TIMEOUT = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busReq,
  input  logic      busWrite,
  input  logic      portAcc,
  input  logic      cfgDone,
  output ctrlStrb_t strb,
  output logic      busReady,
  output logic      cfgReq
);
  localparam int TW = $clog2(TIMEOUT);

  ctrlState_t state, stateNext;
  logic [TW-1:0] waitCnt;
  logic timedOut;

  assign timedOut = (state == ST_WAIT) && !cfgDone && (waitCnt == TW'(TIMEOUT - 1));

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (portAcc) stateNext = ST_WAIT;
      ST_WAIT: if (cfgDone || timedOut) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      else                  waitCnt <= '0;
    end
  end

  always_comb begin
    strb.regWe       = (state == ST_IDLE) && busReq && busWrite && !portAcc;
    strb.respLatch   = (state == ST_WAIT) && cfgDone;
    strb.respTimeout = timedOut;
    strb.respSel     = (state == ST_DONE);
  end

  assign cfgReq   = (state == ST_WAIT);
  assign busReady = (state == ST_DONE) || ((state == ST_IDLE) && !portAcc);

  // R8: no completion while the downstream cycle is still outstanding
  assert_stall_while_cfg_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> !busReady);

  // R8: the done pulse ends the request at the next edge
  assert_req_ends_on_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && cfgDone) |=> !cfgReq);

  // R9: a stuck access is released once the window is used up
  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && waitCnt == TW'(TIMEOUT - 1)) |=> (busReady && !cfgReq));

  // R12: a port access always starts by stalling
  assert_port_stalls_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cfgReq)) |-> $past(busReq));
endmodule

// File: rtl/pci_host_dp.sv
module pci_host_dp
  import pci_host_pkg::*;
#(
  parameter int          HDR_WORDS = 64,
  parameter int          NUM_SRC   = 4,
  parameter int          NUM_LINES = 4,
  parameter int          WIN_BITS  = 18,
  parameter logic [15:0] VENDOR_ID = 16'h1054,
  parameter logic [15:0] DEVICE_ID = 16'h350E
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic                  busReq,
  input  logic [9:0]            busAddr,
  input  logic [3:0]            busBe,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  output logic                  portAcc,
  output logic [31:0]           cfgAddr,
  input  logic [31:0]           cfgRdata,
  input  logic [31:0]           ioAddr,
  output logic                  ioHit,
  output logic [WIN_BITS-1:0]   ioOffset,
  input  logic [NUM_SRC-1:0]    intSrc,
  input  logic [8*NUM_SRC-1:0]  intDevfn,
  output logic [NUM_LINES-1:0]  intLine
);
  localparam int HW = $clog2(HDR_WORDS);

  logic [7:0]  wordIdx;
  logic        fullWord, hdrHit;
  logic [HW-1:0] hdrIdx;
  logic [31:0] hdr [1:HDR_WORDS-1];
  logic [31:0] addrReg, memBase, ioBase, cfgResp, regRd;
  logic        ioWrite;

  assign wordIdx  = busAddr[9:2];
  assign fullWord = (busBe == 4'hF);
  assign hdrHit   = (32'(wordIdx) < HDR_WORDS);
  assign hdrIdx   = wordIdx[HW-1:0];
  assign portAcc  = busReq && fullWord && (wordIdx == IDX_PORT);
  assign ioWrite  = strb.regWe && fullWord && (wordIdx == IDX_IOB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 1; i < HDR_WORDS; i++) hdr[i] <= (i == 1) ? HDR1_RESET : '0;
      addrReg <= '0;
      memBase <= '0;
      ioBase  <= IOB_RESET;
      cfgResp <= '0;
    end else begin
      if (strb.regWe && fullWord) begin
        if (hdrHit && hdrIdx != '0) hdr[hdrIdx] <= busWdata;
        if (wordIdx == IDX_ADDR)  addrReg <= busWdata;
        if (wordIdx == IDX_MBASE) memBase <= busWdata & MBASE_MASK;
      end
      if (ioWrite && (busWdata[31:WIN_BITS] != ioBase[31:WIN_BITS]))
        ioBase <= busWdata & IOB_MASK;
      if (strb.respLatch)        cfgResp <= cfgRdata;
      else if (strb.respTimeout) cfgResp <= '1;
    end
  end

  always_comb begin
    regRd = '0;
    if (hdrHit) regRd = (hdrIdx == '0) ? {DEVICE_ID, VENDOR_ID} : hdr[hdrIdx];
    else if (wordIdx == IDX_ADDR)  regRd = addrReg;
    else if (wordIdx == IDX_MBASE) regRd = memBase;
    else if (wordIdx == IDX_IOB)   regRd = ioBase;
  end

  assign busRdata = strb.respSel ? cfgResp : (fullWord ? regRd : '0);
  assign cfgAddr  = addrReg;

  assign ioHit    = (ioAddr[31:WIN_BITS] == ioBase[31:WIN_BITS]);
  assign ioOffset = ioAddr[WIN_BITS-1:0];

  generate
    for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
      logic [NUM_SRC-1:0] match;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign match[s] = intSrc[s] && (32'(intDevfn[8*s+3 +: 5]) == ln);
      end
      assign intLine[ln] = |match;
    end
  endgenerate

  // R6: a write with the same window bits leaves the register untouched
  assert_iob_same_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrite && busWdata[31:WIN_BITS] == ioBase[31:WIN_BITS]) |=> $stable(ioBase));

  // R5: masked bits of the memory base never become set
  assert_mbase_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    memBase[23:1] == '0);

  // R9: a timeout always leaves all ones for the bus
  assert_timeout_ones_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.respTimeout && !strb.respLatch) |=> (cfgResp == '1));

  // R11: no line is driven while every source is idle
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (intSrc == '0) |-> (intLine == '0));
endmodule

// File: rtl/pci_host_regblk.sv
module pci_host_regblk
  import pci_host_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int TIMEOUT = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReq,
  input  logic                 busWrite,
  input  logic [9:0]           busAddr,
  input  logic [3:0]           busBe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 busReady,
  output logic                 cfgReq,
  output logic                 cfgWrite,
  output logic [31:0]          cfgAddr,
  output logic [31:0]          cfgWdata,
  input  logic                 cfgDone,
  input  logic [31:0]          cfgRdata,
  input  logic [31:0]          ioAddr,
  output logic                 ioHit,
  output logic [17:0]          ioOffset,
  input  logic [NUM_SRC-1:0]   intSrc,
  input  logic [8*NUM_SRC-1:0] intDevfn,
  output logic [3:0]           intLine
);
  ctrlStrb_t strb;
  logic portAcc;

  pci_host_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .portAcc(portAcc), .cfgDone(cfgDone), .strb(strb),
    .busReady(busReady), .cfgReq(cfgReq)
  );

  pci_host_dp #(.NUM_SRC(NUM_SRC), .NUM_LINES(4), .WIN_BITS(18)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busReq(busReq),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .busRdata(busRdata), .portAcc(portAcc), .cfgAddr(cfgAddr),
    .cfgRdata(cfgRdata), .ioAddr(ioAddr), .ioHit(ioHit),
    .ioOffset(ioOffset), .intSrc(intSrc), .intDevfn(intDevfn),
    .intLine(intLine)
  );

  assign cfgWrite = busWrite;
  assign cfgWdata = busWdata;
endmodule

// File: tb/pci_host_regblk_test.sv
`timescale 1ns/1ps
module pci_host_regblk_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, busWrite = 1'b0;
  logic [9:0] busAddr = '0;
  logic [3:0] busBe = 4'hF;
  logic [31:0] busWdata = '0, busRdata;
  logic busReady, cfgReq, cfgWrite;
  logic [31:0] cfgAddr, cfgWdata;
  logic cfgDone = 1'b0;
  logic [31:0] cfgRdata = '0;
  logic [31:0] ioAddr = '0;
  logic ioHit;
  logic [17:0] ioOffset;
  logic [3:0] intSrc = '0;
  logic [31:0] intDevfn = '0;
  logic [3:0] intLine;

  int checks = 0, failures = 0;
  int lat = 2;
  logic respondEn = 1'b1;
  int dsCnt = 0;
  logic [31:0] dsMem [0:63];
  logic [31:0] lastAddr = '0, lastWdata = '0;

  always #4 clk = ~clk;

  pci_host_regblk uut (.*);

  // downstream configuration responder
  always @(posedge clk) begin
    cfgDone <= 1'b0;
    if (cfgReq && !cfgDone && respondEn) begin
      if (dsCnt == lat) begin
        cfgDone  <= 1'b1;
        dsCnt    <= 0;
        cfgRdata <= dsMem[cfgAddr[7:2]];
        lastAddr <= cfgAddr;
        if (cfgWrite) begin
          dsMem[cfgAddr[7:2]] <= cfgWdata;
          lastWdata <= cfgWdata;
        end
      end else dsCnt <= dsCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [9:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd, output int stalls);
    @(negedge clk);
    busReq = 1'b1; busWrite = w; busAddr = a; busWdata = d; busBe = be;
    stalls = 0;
    #1;
    while (!busReady && stalls < 2000) begin
      @(negedge clk); #1; stalls++;
    end
    rd = busRdata;
    @(posedge clk); #1;
    busReq = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] rd; int st;
    xfer(1'b1, a, d, 4'hF, rd, st);
  endtask

  task automatic rdReg(input logic [9:0] a, output logic [31:0] rd);
    int st;
    xfer(1'b0, a, '0, 4'hF, rd, st);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(10'h004, v); check("R3 header dword1", v, 32'h0290_0080);
    rdReg(10'h1C8, v); check("R3 io base", v, 32'hFE24_0000);
    rdReg(10'h1C0, v); check("R3 addr latch", v, 32'h0);
    rdReg(10'h1C4, v); check("R3 mem base", v, 32'h0);
  endtask

  task automatic testHeader();
    logic [31:0] v;
    wr(10'h010, 32'hA5A5_1234); rdReg(10'h010, v); check("R1 header dword4", v, 32'hA5A5_1234);
    wr(10'h0FC, 32'h0BAD_F00D); rdReg(10'h0FC, v); check("R1 header dword63", v, 32'h0BAD_F00D);
    rdReg(10'h000, v); check("R2 id dword", v, 32'h350E_1054);
    wr(10'h000, 32'h1111_2222); rdReg(10'h000, v); check("R2 id after write", v, 32'h350E_1054);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    wr(10'h1C0, 32'hDEAD_BEEF); rdReg(10'h1C0, v); check("R4 addr latch", v, 32'hDEAD_BEEF);
    wr(10'h1C4, 32'hFFFF_FFFF); rdReg(10'h1C4, v); check("R5 mem base mask", v, 32'hFF00_0001);
  endtask

  task automatic testIoBase();
    logic [31:0] v;
    wr(10'h1C8, 32'hFE27_0001); rdReg(10'h1C8, v); check("R6 same window ignored", v, 32'hFE24_0000);
    wr(10'h1C8, 32'h1003_FFFF); rdReg(10'h1C8, v); check("R6 new window masked", v, 32'h1000_0001);
    wr(10'h1C8, 32'h1000_0000); rdReg(10'h1C8, v); check("R6 bit0 kept", v, 32'h1000_0001);
  endtask

  task automatic testUnmapped();
    logic [31:0] v; int st;
    xfer(1'b1, 10'h1C0, 32'h0000_0055, 4'h3, v, st);
    rdReg(10'h1C0, v); check("R7 partial write dropped", v, 32'hDEAD_BEEF);
    xfer(1'b0, 10'h1C0, '0, 4'h3, v, st); check("R7 partial read zero", v, 32'h0);
    check("R7 partial no stall", 32'(st), 32'd0);
    rdReg(10'h100, v); check("R7 unmapped read", v, 32'h0);
    wr(10'h1CC, 32'h7777_7777); rdReg(10'h1CC, v); check("R7 unmapped write", v, 32'h0);
    xfer(1'b0, 10'h220, '0, 4'h1, v, st); check("R7 partial port no stall", 32'(st), 32'd0);
  endtask

  task automatic testCfgPort();
    logic [31:0] v; int st;
    wr(10'h1C0, 32'h8000_0810);
    lat = 2;
    xfer(1'b1, 10'h220, 32'hCAFE_0001, 4'hF, v, st);
    check("R12 write stall cycles", 32'(st), 32'd5);
    check("R8 cfg address", lastAddr, 32'h8000_0810);
    check("R8 cfg write data", lastWdata, 32'hCAFE_0001);
    lat = 0;
    xfer(1'b0, 10'h220, '0, 4'hF, v, st);
    check("R8 cfg read data", v, 32'hCAFE_0001);
    check("R12 read stall cycles", 32'(st), 32'd3);
  endtask

  task automatic testTimeout();
    logic [31:0] v; int st;
    respondEn = 1'b0;
    xfer(1'b0, 10'h220, '0, 4'hF, v, st);
    check("R9 timeout data", v, 32'hFFFF_FFFF);
    check("R9 timeout stall cycles", 32'(st), 32'd257);
    respondEn = 1'b1;
    rdReg(10'h1C0, v); check("R9 bus usable after timeout", v, 32'h8000_0810);
  endtask

  task automatic testIoWindow();
    @(negedge clk); ioAddr = 32'h1003_FFFC; #1;
    check("R10 hit top", {31'b0, ioHit}, 32'd1);
    check("R10 offset", {14'b0, ioOffset}, 32'h3FFFC);
    @(negedge clk); ioAddr = 32'h1004_0000; #1;
    check("R10 miss above", {31'b0, ioHit}, 32'd0);
    @(negedge clk); ioAddr = 32'h1000_0000; #1;
    check("R10 hit base", {31'b0, ioHit}, 32'd1);
  endtask

  task automatic testIrq();
    @(negedge clk);
    intDevfn = {8'h00, 8'h28, 8'h11, 8'h10};
    intSrc = 4'b0100; #1;
    check("R11 device five no line", {28'b0, intLine}, 32'h0);
    @(negedge clk); intSrc = 4'b0001; #1;
    check("R11 device two", {28'b0, intLine}, 32'h4);
    @(negedge clk); intSrc = 4'b1010; #1;
    check("R11 two sources", {28'b0, intLine}, 32'h5);
    @(negedge clk); intSrc = 4'b0000;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) dsMem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testHeader();
    testRegs();
    testIoBase();
    testUnmapped();
    testCfgPort();
    testTimeout();
    testIoWindow();
    testIrq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule